// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Reads

This block is a 16-bit up-counter that runs freely from the bus clock. It advances on a single-cycle count enable from a divider chain, which divides by a power of two from 1 to 64. A three-bit select field picks the ratio, and one code stops the counter. Software sees the counter through an 8-bit register port as two byte registers. When the high byte is read, the low byte is frozen into a holding register at the same moment. A high-then-low read pair therefore returns one coherent 16-bit value even while the counter keeps running.

A control register holds the divide select. It also has a self-clearing counter-reset bit. Writing that bit zeroes the counter, restarts the divider chain and drops any frozen low byte. The counter wraps from its top value to zero, and each wrap is flagged by a one-cycle overflow pulse. Everything runs in one clock domain.

Top module: `ptc_timer`

## Requirements
- R1: After reset the counter is 0x0000, the divide select is 0 (divide by 1), no low byte is frozen, and the control register (address 0) reads 0x00.
- R2: Select codes 0 to 6 (control bits [2:0]) make the counter advance once every 2^code bus clocks. After a counter reset, the first advance comes on the 2^code-th edge.
- R3: Select code 7 stops the counter, and it keeps its value until the code changes.
- R4: Writes to address 1 (high byte) and address 2 (low byte) leave the counter unchanged.
- R5: A read at address 1 returns counter bits [15:8]. On the same edge, it freezes counter bits [7:0] into a holding register, and the next read at address 2 returns that frozen byte and releases it.
- R6: While a low byte is frozen, further reads at address 1 do not refresh the holding register.
- R7: A read at address 2 with no byte frozen returns the live counter bits [7:0].
- R8: Writing control bit 7 as 1 clears the counter to 0, restarts the divider chain and releases a frozen low byte. Bit 7 always reads back as 0, and address 3 reads as 0x00.
- R9: When the counter wraps from 0xFFFF to 0x0000, `overflow` is high for exactly the one cycle in which the counter first shows 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| addr | input | 2 | Register address: 0 control, 1 count high, 2 count low, 3 reserved |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| overflow | output | 1 | One-cycle pulse after the counter wraps |

## Verification
The hardest state to reach is a wrap, because it takes 65,536 count enables. The stimulus gets there by clearing the counter at divide-by-1 and idling through the whole range, and it reads both bytes around the wrap. A second hard case is a frozen low byte that goes stale while the counter runs on. To reach it, the bench holds the buffer across several idle cycles and repeated high-byte reads. It also clears the counter while the buffer is held, so it can see whether the release happens.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 2;
  // control register: [SEL_W-1:0] divide select, [CLR_BIT] counter reset
  localparam int CLR_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 2;

  logic [DIV_W-1:0] phase;

  // due when the low 'sel' bits of the phase are all ones; all-ones select stops
  function automatic logic tick_due(input logic [SEL_W-1:0] s, input logic [DIV_W-1:0] p);
    logic [DIV_W-1:0] mask;
    if (s == {SEL_W{1'b1}}) return 1'b0;
    mask = '0;
    for (int i = 0; i < DIV_W; i++)
      if (i < int'(s)) mask[i] = 1'b1;
    return (p & mask) == mask;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else              phase <= phase + DIV_W'(1);
  end

  always_comb tick = tick_due(sel, phase);

  // a dividing ratio never yields two enables in a row
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick) && !$past(restart) && $stable(sel) && sel != '0) |-> !tick);
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic wrap_evt;

  function automatic logic [CNT_W-1:0] next_value(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign wrap_evt = tick && !clr && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= wrap_evt;
      if (clr)       count <= '0;
      else if (tick) count <= next_value(count);
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick) && !$past(clr)) |-> count == $past(count) + CNT_W'(1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick) && !$past(clr)) |-> $stable(count));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr)) |-> count == '0);
  assert_ovf_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));
endmodule

// File: rtl/ptc_readlatch.sv
module ptc_readlatch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic [BYTE_W-1:0] live_lo,
  output logic [BYTE_W-1:0] lo_view,
  output logic              held
);
  logic [BYTE_W-1:0] snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      snap <= '0;
    end else if (clr || rd_lo) begin
      held <= 1'b0;
    end else if (rd_hi && !held) begin
      held <= 1'b1;
      snap <= live_lo;
    end
  end

  assign lo_view = held ? snap : live_lo;

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_hi) && !$past(held) && !$past(clr)) |-> (held && lo_view == $past(live_lo)));
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(held) && held) |-> $stable(snap));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr)) |-> !held);
endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              overflow
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [SEL_W-1:0]  sel_q;
  logic              wr_ctrl, clr_pulse, rd_hi, rd_lo, tick, held;
  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] lo_view;
  logic              ctrl_unused_bits;

  assign wr_ctrl          = wr_en && (addr == REG_CTRL);
  assign clr_pulse        = wr_ctrl && wdata[CLR_BIT];
  assign rd_hi            = rd_en && (addr == REG_CNT_HI);
  assign rd_lo            = rd_en && (addr == REG_CNT_LO);
  assign ctrl_unused_bits = ^wdata[CLR_BIT-1:SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= '0;
    else if (wr_ctrl) sel_q <= wdata[SEL_W-1:0];
  end

  ptc_prescaler #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(clr_pulse), .sel(sel_q), .tick(tick)
  );

  ptc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .tick(tick), .count(count), .ovf(overflow)
  );

  ptc_readlatch #(.BYTE_W(BYTE_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .live_lo(count[BYTE_W-1:0]), .lo_view(lo_view), .held(held)
  );

  always_comb begin
    case (reg_addr_e'(addr))
      REG_CTRL:   rdata = BYTE_W'(sel_q);
      REG_CNT_HI: rdata = count[CNT_W-1:BYTE_W];
      REG_CNT_LO: rdata = lo_view;
      default:    rdata = '0;
    endcase
  end

  assert_hold_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(addr) != REG_CTRL && !$past(tick)) |-> $stable(count));
  assert_held_after_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_hi) && !$past(clr_pulse)) |-> held);
endmodule

// File: tb/ptc_timer_test.sv
module ptc_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       overflow;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  // reference state
  int unsigned m_cnt = 0, m_phase = 0, m_sel = 0;
  bit          m_held = 0, m_ovf = 0;
  logic [7:0]  m_snap = 8'd0;

  ptc_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .overflow(overflow));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    bit due, clr;
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_sel = 0; m_held = 0; m_ovf = 0; m_snap = 8'd0;
    end else begin
      due = (m_sel != 7) && (((m_phase + 1) % (1 << m_sel)) == 0);
      clr = wr_en && addr == 2'd0 && wdata[7];
      m_ovf = !clr && due && m_cnt == 16'hFFFF;
      if (clr || (rd_en && addr == 2'd2)) m_held = 0;
      else if (rd_en && addr == 2'd1 && !m_held) begin m_held = 1; m_snap = m_cnt[7:0]; end
      if (clr) begin m_cnt = 0; m_phase = 0; end
      else begin
        if (due) m_cnt = (m_cnt + 1) % 65536;
        m_phase = m_phase + 1;
      end
      if (wr_en && addr == 2'd0) m_sel = wdata[2:0];
    end
  end

  task automatic op_idle(int n);
    repeat (n) begin @(negedge clk); rd_en = 0; wr_en = 0; end
  endtask

  task automatic op_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); rd_en = 0; wr_en = 1; addr = a; wdata = d;
  endtask

  task automatic op_read(logic [1:0] a, string tag);
    item_t it;
    @(negedge clk); wr_en = 0; rd_en = 1; addr = a;
    case (a)
      2'd0: it.exp = 8'(m_sel);
      2'd1: it.exp = 8'(m_cnt >> 8);
      2'd2: it.exp = m_held ? m_snap : 8'(m_cnt);
      default: it.exp = 8'd0;
    endcase
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: sample away from the rising edge
  always @(negedge clk) begin
    item_t it;
    #1;
    if (rst_n && !done) begin
      if (rd_en && sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, addr, rdata, it.exp);
        end
      end
      if (m_ovf || overflow !== 1'b0) begin
        checks++;
        if (overflow !== m_ovf) begin
          fails++;
          $display("FAIL R9 overflow actual=%0b expected=%0b", overflow, m_ovf);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    op_read(2'd0, "R1 ctrl after reset");
    op_read(2'd1, "R1 high after reset");
    op_read(2'd2, "R1 low after reset");
    // R7 live low reads
    op_idle(3);
    op_read(2'd2, "R7 live low");
    op_idle(2);
    op_read(2'd2, "R7 live low again");
    // R5 coherent pair
    op_read(2'd1, "R5 high");
    op_idle(5);
    op_read(2'd2, "R5 frozen low");
    op_read(2'd2, "R7 low after release");
    // R6 repeated high reads
    op_read(2'd1, "R6 first high");
    op_idle(3);
    op_read(2'd1, "R6 second high");
    op_idle(3);
    op_read(2'd2, "R6 low keeps first snapshot");
    // R4 writes to counter bytes ignored
    op_write(2'd1, 8'hAA);
    op_write(2'd2, 8'h55);
    op_read(2'd2, "R4 low after writes");
    op_read(2'd1, "R4 high after writes");
    op_read(2'd2, "R4 low pair");
    // R2 every divide ratio, restarted by counter reset
    for (int s = 0; s < 7; s++) begin
      op_write(2'd0, 8'h80 | 8'(s));
      op_idle((s + 1) * 9);
      op_read(2'd2, "R2 low after run");
      op_read(2'd1, "R2 high after run");
      op_read(2'd2, "R2 low pair");
      op_read(2'd0, "R8 ctrl reset bit reads 0");
    end
    // R3 stopped
    op_write(2'd0, 8'h00);
    op_idle(20);
    op_write(2'd0, 8'h07);
    op_idle(30);
    op_read(2'd2, "R3 stopped low");
    op_idle(50);
    op_read(2'd2, "R3 still stopped low");
    op_read(2'd1, "R3 still stopped high");
    op_read(2'd2, "R3 pair");
    // R8 clear releases held byte
    op_write(2'd0, 8'h00);
    op_idle(40);
    op_read(2'd1, "R8 high before clear");
    op_idle(2);
    op_write(2'd0, 8'h80);
    op_idle(4);
    op_read(2'd2, "R8 low live after clear");
    op_read(2'd3, "R8 spare reads zero");
    // R9 wrap
    op_write(2'd0, 8'h80);
    op_idle(65530);
    op_read(2'd1, "R9 high before wrap");
    op_read(2'd2, "R9 low before wrap");
    op_idle(6);
    op_read(2'd2, "R9 low after wrap");
    op_read(2'd1, "R9 high after wrap");
    op_read(2'd2, "R9 pair after wrap");
    op_idle(4);
    wait (sb.size() == 0);
    op_idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule